// File: doc/BRIEF.md
# Rail Fault and Thermal Supervisor

This block watches a set of supply rails and the die temperature and decides when the fault output goes active and which regulators must be turned off. Every rail brings a digital undervoltage flag from an external comparator that trips below roughly 80% of the set value. It also brings a signal saying its ramp has finished, a tag saying whether an internal regulator drives the rail or an external pass device does, and a tag marking it as a standby rail. The main supply rails bring undervoltage flags of their own. Two temperature flags report the lower (warning) threshold and the upper (critical) threshold.

All flags pass through two flip-flops before use. A fault on an externally passed rail only raises the fault output. A fault on an internally regulated rail also latches off that rail's own regulator. If a standby rail faults while the initial window after bias power-on-reset is open, the whole block latches off, and only a new power-on-reset (`rstN`) clears it. When the die crosses the critical threshold, every output shuts off until the temperature drops below the warning threshold. A shutdown request forces the fault output low, holds every output off and clears the per-rail latches.

Top module: `rail_fault_supervisor`

## Requirements
- R1: `faultOut` goes high on the third rising clock edge after an armed rail undervoltage, any main-supply undervoltage or the warning temperature flag appears, with no shutdown request present. It falls with the same latency once every such condition has cleared and the block is not latched off.
- R2: An undervoltage flag on a rail whose `railArmed` bit is 0 is ignored. It raises neither `faultOut` nor any `railOff` bit.
- R3: An armed undervoltage on a rail whose `railInternal` bit is 0 raises `faultOut` only. Its `railOff` bit stays 0, both during the fault and after it clears.
- R4: An armed undervoltage on a rail whose `railInternal` bit is 1 sets that rail's `railOff` bit, which stays set after the flag clears, until a shutdown request.
- R5: An armed undervoltage on a rail whose `railStandby` bit is 1, while `initWindow` is 1, sets `latchedOff`, `allOff` and `faultOut`. These hold after the flag clears. A shutdown request only masks `faultOut` and does not clear them; only `rstN` low clears them.
- R6: The warning temperature flag alone raises `faultOut` and leaves `allOff` at 0.
- R7: The critical temperature flag sets `allOff`. `allOff` stays set while the warning flag remains high, even after the critical flag clears, and drops once the warning flag clears.
- R8: While `shutdownReq` is 1, from the next clock edge `faultOut` is 0 and all `railOff` bits are 0, and `allOff` is 1 combinationally.
- R9: After reset `faultOut`, `railOff`, `allOff` and `latchedOff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Active-low bias power-on-reset, asynchronous |
| shutdownReq | input | 1 | Global shutdown request |
| initWindow | input | 1 | High during the first ramp after power-on-reset |
| railUv | input | NUM_RAILS | Per-rail undervoltage flags (asynchronous) |
| railArmed | input | NUM_RAILS | Per-rail ramp-finished, arms monitoring |
| railInternal | input | NUM_RAILS | 1 = internal regulator, 0 = external pass device |
| railStandby | input | NUM_RAILS | 1 = standby rail subject to first-ramp latch-off |
| mainUv | input | NUM_MAIN | Main supply undervoltage flags (asynchronous) |
| tempWarn | input | 1 | Die above warning threshold |
| tempCrit | input | 1 | Die above critical threshold |
| faultOut | output | 1 | Fault indication |
| railOff | output | NUM_RAILS | Latched per-rail regulator shutoff |
| allOff | output | 1 | Shut off every output |
| latchedOff | output | 1 | Block latched off since first ramp |

## Verification
The bench aims at the split between rail kinds. A design that latched external rails would leave a `railOff` bit set after an external fault. A design that did not hold internal latches would drop the bit once the flag clears. The bench also walks the thermal hysteresis: critical high, then critical low with warning high, then warning low. A design without hysteresis would release `allOff` one step early. The last part drives a standby fault inside the initial window and then applies a shutdown. A design that let shutdown clear the latch-off would bring `faultOut` back low after the release.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef struct packed {
    logic anyRailUv;
    logic standbyUv;
    logic mainUv;
    logic tempWarn;
    logic tempCrit;
  } supv_status_t;

  typedef struct packed {
    logic clearRails;
    logic holdRails;
  } supv_ctrl_t;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int NUM_RAILS = 5,
  parameter int NUM_MAIN  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RAILS-1:0] railUv,
  input  logic [NUM_RAILS-1:0] railArmed,
  input  logic [NUM_RAILS-1:0] railInternal,
  input  logic [NUM_RAILS-1:0] railStandby,
  input  logic [NUM_MAIN-1:0]  mainUv,
  input  logic                 tempWarn,
  input  logic                 tempCrit,
  input  supv_ctrl_t           ctrl,
  output supv_status_t         status,
  output logic [NUM_RAILS-1:0] railOff
);
  localparam int SYNC_W = NUM_RAILS + NUM_MAIN + 2;

  logic [SYNC_W-1:0]    rawFlags;
  logic [SYNC_W-1:0]    syncFlags;
  logic [NUM_RAILS-1:0] railUvSync;
  logic [NUM_MAIN-1:0]  mainUvSync;
  logic [NUM_RAILS-1:0] qualifiedUv;
  logic [NUM_RAILS-1:0] offLatch;

  assign rawFlags = {tempCrit, tempWarn, mainUv, railUv};

  supv_sync #(.WIDTH(SYNC_W)) flagSync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawFlags),
    .syncOut (syncFlags)
  );

  assign railUvSync  = syncFlags[NUM_RAILS-1:0];
  assign mainUvSync  = syncFlags[NUM_RAILS +: NUM_MAIN];
  assign qualifiedUv = railUvSync & railArmed;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        offLatch[i] <= 1'b0;
      else if (ctrl.clearRails)
        offLatch[i] <= 1'b0;
      else if (!ctrl.holdRails && qualifiedUv[i] && railInternal[i])
        offLatch[i] <= 1'b1;
    end
  end

  assign status.anyRailUv = |qualifiedUv;
  assign status.standbyUv = |(qualifiedUv & railStandby);
  assign status.mainUv    = |mainUvSync;
  assign status.tempWarn  = syncFlags[SYNC_W-2];
  assign status.tempCrit  = syncFlags[SYNC_W-1];
  assign railOff          = offLatch;
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         shutdownReq,
  input  logic         initWindow,
  input  supv_status_t status,
  output supv_ctrl_t   ctrl,
  output logic         faultOut,
  output logic         allOff,
  output logic         latchedOff
);
  typedef enum logic {THERM_RUN, THERM_OFF} therm_state_t;

  therm_state_t thermState;
  logic         latchOffQ;
  logic         faultQ;
  logic         faultNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermState <= THERM_RUN;
    end else begin
      unique case (thermState)
        THERM_RUN: if (status.tempCrit) thermState <= THERM_OFF;
        THERM_OFF: if (!status.tempWarn && !status.tempCrit) thermState <= THERM_RUN;
        default:   thermState <= THERM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      latchOffQ <= 1'b0;
    else if (initWindow && status.standbyUv)
      latchOffQ <= 1'b1;
  end

  always_comb begin
    faultNext = latchOffQ | status.anyRailUv | status.standbyUv |
                status.mainUv | status.tempWarn | status.tempCrit;
    if (shutdownReq) faultNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= 1'b0;
    else       faultQ <= faultNext;
  end

  assign ctrl.clearRails = shutdownReq;
  assign ctrl.holdRails  = latchOffQ;
  assign faultOut        = faultQ;
  assign latchedOff      = latchOffQ;
  assign allOff          = latchOffQ | (thermState == THERM_OFF) | shutdownReq;
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
  import supv_pkg::*;
#(
  parameter int NUM_RAILS = 5,
  parameter int NUM_MAIN  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 shutdownReq,
  input  logic                 initWindow,
  input  logic [NUM_RAILS-1:0] railUv,
  input  logic [NUM_RAILS-1:0] railArmed,
  input  logic [NUM_RAILS-1:0] railInternal,
  input  logic [NUM_RAILS-1:0] railStandby,
  input  logic [NUM_MAIN-1:0]  mainUv,
  input  logic                 tempWarn,
  input  logic                 tempCrit,
  output logic                 faultOut,
  output logic [NUM_RAILS-1:0] railOff,
  output logic                 allOff,
  output logic                 latchedOff
);
  supv_status_t status;
  supv_ctrl_t   ctrl;

  supv_datapath #(.NUM_RAILS(NUM_RAILS), .NUM_MAIN(NUM_MAIN)) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .railUv       (railUv),
    .railArmed    (railArmed),
    .railInternal (railInternal),
    .railStandby  (railStandby),
    .mainUv       (mainUv),
    .tempWarn     (tempWarn),
    .tempCrit     (tempCrit),
    .ctrl         (ctrl),
    .status       (status),
    .railOff      (railOff)
  );

  supv_control control_i (
    .clk         (clk),
    .rstN        (rstN),
    .shutdownReq (shutdownReq),
    .initWindow  (initWindow),
    .status      (status),
    .ctrl        (ctrl),
    .faultOut    (faultOut),
    .allOff      (allOff),
    .latchedOff  (latchedOff)
  );
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int NUM_RAILS = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 shutdownReq,
  input logic [NUM_RAILS-1:0] railInternal,
  input logic                 faultOut,
  input logic [NUM_RAILS-1:0] railOff,
  input logic                 allOff,
  input logic                 latchedOff
);
  a_r8_shutdown_masks_fault: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> !faultOut);

  a_r8_shutdown_clears_rails: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> (railOff == '0));

  a_r5_latch_persists: assert property (@(posedge clk) disable iff (!rstN)
    latchedOff |=> latchedOff);

  a_r5_latch_drives_fault: assert property (@(posedge clk) disable iff (!rstN)
    (latchedOff && !$past(shutdownReq)) |-> (faultOut && allOff));

  a_r3_external_never_latched: assert property (@(posedge clk) disable iff (!rstN)
    ((railOff & ~$past(railOff) & ~$past(railInternal)) == '0));

  a_r4_rail_off_with_fault: assert property (@(posedge clk) disable iff (!rstN)
    ((railOff & ~$past(railOff)) != '0) |-> faultOut);
endmodule

bind rail_fault_supervisor supv_checker #(.NUM_RAILS(NUM_RAILS)) checker_i (.*);

// File: tb/rail_fault_supervisor_tb_top.sv
module rail_fault_supervisor_tb_top;
  localparam int NR = 5;
  localparam int NM = 3;

  typedef struct {
    string       tag;
    logic        fault;
    logic [NR-1:0] off;
    logic        all;
    logic        lat;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shutdownReq = 1'b0;
  logic initWindow = 1'b0;
  logic [NR-1:0] railUv = '0;
  logic [NR-1:0] railArmed = '0;
  logic [NR-1:0] railInternal = 5'b10011;
  logic [NR-1:0] railStandby = 5'b00101;
  logic [NM-1:0] mainUv = '0;
  logic tempWarn = 1'b0;
  logic tempCrit = 1'b0;
  logic faultOut;
  logic [NR-1:0] railOff;
  logic allOff;
  logic latchedOff;

  int checks = 0;
  int fails = 0;
  exp_t expQ[$];
  bit done = 0;

  always #5 clk = ~clk;

  rail_fault_supervisor #(.NUM_RAILS(NR), .NUM_MAIN(NM)) dut_i (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectNow(input string tag, input logic f, input logic [NR-1:0] o,
                           input logic a, input logic l);
    exp_t e;
    e.tag = tag; e.fault = f; e.off = o; e.all = a; e.lat = l;
    expQ.push_back(e);
    #1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (expQ.size() != 0);
      e = expQ.pop_front();
      checks++;
      if (faultOut !== e.fault || railOff !== e.off || allOff !== e.all || latchedOff !== e.lat) begin
        fails++;
        $display("FAIL %s: got fault=%b off=%b all=%b lat=%b, expected fault=%b off=%b all=%b lat=%b",
                 e.tag, faultOut, railOff, allOff, latchedOff, e.fault, e.off, e.all, e.lat);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    expectNow("R9 reset state", 0, 5'b0, 0, 0);
    rstN = 1'b1;
    step(2);

    railUv = 5'b01000;
    step(3);
    expectNow("R2 unarmed rail ignored", 0, 5'b0, 0, 0);
    railUv = '0;
    railArmed = 5'b11111;
    step(3);

    railUv = 5'b01000;
    step(3);
    expectNow("R3 external rail flags fault", 1, 5'b0, 0, 0);
    railUv = '0;
    step(3);
    expectNow("R3 external rail no latch", 0, 5'b0, 0, 0);

    railUv = 5'b00010;
    step(3);
    expectNow("R4 internal rail shut off", 1, 5'b00010, 0, 0);
    railUv = '0;
    step(3);
    expectNow("R4 internal shutoff held", 0, 5'b00010, 0, 0);

    mainUv = 3'b010;
    step(3);
    expectNow("R1 main supply fault", 1, 5'b00010, 0, 0);
    mainUv = '0;
    step(3);
    expectNow("R1 fault clears", 0, 5'b00010, 0, 0);

    railUv = 5'b01000;
    step(3);
    shutdownReq = 1'b1;
    step(1);
    expectNow("R8 shutdown masks fault, clears rails", 0, 5'b0, 1, 0);
    railUv = '0;
    step(3);
    shutdownReq = 1'b0;
    step(1);
    expectNow("R8 shutdown released", 0, 5'b0, 0, 0);

    tempWarn = 1'b1;
    step(3);
    expectNow("R6 warning only flags", 1, 5'b0, 0, 0);
    tempCrit = 1'b1;
    step(3);
    expectNow("R7 critical shuts all", 1, 5'b0, 1, 0);
    tempCrit = 1'b0;
    step(3);
    expectNow("R7 hysteresis holds off", 1, 5'b0, 1, 0);
    tempWarn = 1'b0;
    step(3);
    expectNow("R7 resume below warning", 0, 5'b0, 0, 0);

    initWindow = 1'b1;
    railUv = 5'b00100;
    step(3);
    expectNow("R5 standby fault latches off", 1, 5'b0, 1, 1);
    railUv = '0;
    initWindow = 1'b0;
    step(3);
    expectNow("R5 latch-off holds", 1, 5'b0, 1, 1);
    shutdownReq = 1'b1;
    step(1);
    expectNow("R5 shutdown masks fault only", 0, 5'b0, 1, 1);
    shutdownReq = 1'b0;
    step(1);
    expectNow("R5 fault returns after shutdown", 1, 5'b0, 1, 1);
    rstN = 1'b0;
    step(1);
    expectNow("R9 reset clears latch-off", 0, 5'b0, 0, 0);
    step(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule